// File: doc/BRIEF.md
# Interrupt Control and Flag Register

This block is the 8-bit interrupt control register of a small microcontroller core. It holds five enable bits and three sticky event flags. The flags record three kinds of event: a timer rollover pulse, a rising edge on an asynchronous external pin, and a change of state on any enabled pin of a general-purpose port. The block also merges the enables, the flags and an external peripheral-group pending line into one registered interrupt request to the core.

Software reads the whole register at any time through `rd_data`. A one-cycle `wr_en` loads `wr_data` into the register. Writing a flag bit to 0 clears it. Writing it to 1 sets it. A flag latches its event whatever the enables hold, so software should clear stale flags before it turns on an enable. The external pin and the port pins pass through a two-flop synchronizer before any edge or change is detected.

Top module: `intc_reg`

## Requirements
- R1: The register bit order from bit 7 down to bit 0 is: global enable, peripheral enable, timer enable, external enable, port-change enable, timer flag, external flag, port-change flag. A write loads bits 7..3 from `wr_data`, and `rd_data` shows the new value after the write edge.
- R2: A flag sets on its event even when its own enable and the global enable are both 0.
- R3: A flag stays set until a write puts a 0 in its bit position. Writing a 1 to a flag bit sets that flag.
- R4: While the global enable (bit 7) is 0, `irq` is 0 at the next clock edge.
- R5: `irq` is a register. At each edge it loads the global enable ANDed with the OR of four terms: (timer enable AND timer flag), (external enable AND external flag), (port-change enable AND port-change flag) and (peripheral enable AND `periph_pend`). All values are taken at that edge.
- R6: While the peripheral enable (bit 6) is 0, `periph_pend` cannot assert `irq`, even with the global enable at 1.
- R7: A one-cycle `tmr_roll` pulse sets the timer flag (bit 2) at the same clock edge that samples the pulse.
- R8: A rising edge on `ext_pin` sets the external flag (bit 1) at the third clock edge after the pin changes. A falling edge has no effect.
- R9: A change in either direction on a port pin whose `pin_chg_en` bit is 1 sets the port-change flag (bit 0) at the third clock edge after the pin changes. A change on a pin whose enable bit is 0 has no effect.
- R10: If an event sets a flag in the same cycle that a write puts a 0 in that flag's bit, the flag ends up set.
- R11: Synchronous reset clears bits 7..1 and `irq`. Bit 0 takes the value of parameter CHG_INIT, which defaults to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| tmr_roll | input | 1 | Timer rollover pulse, synchronous to clk |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | PINS | Asynchronous port pins watched for change |
| pin_chg_en | input | PINS | Per-pin change-detect enable mask |
| periph_pend | input | 1 | Peripheral-group pending request |
| irq | output | 1 | Registered interrupt request to the core |

## Verification
The bench targets a rollover that lands in the same cycle as a clearing write. A design that let the write win would lose the timer event and read bit 2 as 0. It checks the flag on the exact edge in the synchronizer pipeline, so a missing or extra synchronizer stage shows up as a flag that sets one edge early or one edge late. It also applies a falling external edge, a change on a masked port pin and a falling change on an enabled pin. A design that got these wrong would ignore the enabled falling change, or set flags on the other two stimuli. Random write, rollover and pending traffic is compared against a bench model of the request equation, which catches a peripheral path that skips the peripheral enable or a request that ignores the global enable.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned N_FLAGS = 3;
  localparam int unsigned FL_TMR  = 2;
  localparam int unsigned FL_EXT  = 1;
  localparam int unsigned FL_CHG  = 0;

  typedef struct packed {
    logic glb_en;
    logic per_en;
    logic tmr_en;
    logic ext_en;
    logic chg_en;
    logic tmr_fl;
    logic ext_fl;
    logic chg_fl;
  } ictl_reg_t;
endpackage

// File: rtl/ictl_sync.sv
module ictl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ictl_event_det.sv
module ictl_event_det #(
  parameter int unsigned W          = 1,
  parameter bit          ANY_CHANGE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] s,
  input  logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= s;
  end

  if (ANY_CHANGE) begin : g_change
    assign hit = |((s ^ prev) & mask);
  end else begin : g_rise
    assign hit = |(s & ~prev & mask);
  end
endmodule

// File: rtl/ictl_flag.sv
module ictl_flag #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic wr,
  input  logic wd,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= INIT;
    else if (set) q <= 1'b1;
    else if (wr)  q <= wd;
  end
endmodule

// File: rtl/intc_reg.sv
module intc_reg #(
  parameter int unsigned PINS        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          CHG_INIT    = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic            tmr_roll,
  input  logic            ext_pin,
  input  logic [PINS-1:0] port_pins,
  input  logic [PINS-1:0] pin_chg_en,
  input  logic            periph_pend,
  output logic            irq
);
  import ictl_pkg::*;

  localparam int unsigned EN_LO = N_FLAGS;

  ictl_reg_t r;
  logic [N_FLAGS-1:0] fl_set;
  logic [N_FLAGS-1:0] fl_q;
  logic               ext_s;
  logic [PINS-1:0]    pins_s;
  logic               ext_hit;
  logic               chg_hit;

  ictl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ext (
    .clk(clk), .rst(rst), .d(ext_pin), .q(ext_s)
  );

  ictl_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync_pins (
    .clk(clk), .rst(rst), .d(port_pins), .q(pins_s)
  );

  ictl_event_det #(.W(1), .ANY_CHANGE(1'b0)) u_det_ext (
    .clk(clk), .rst(rst), .s(ext_s), .mask(1'b1), .hit(ext_hit)
  );

  ictl_event_det #(.W(PINS), .ANY_CHANGE(1'b1)) u_det_chg (
    .clk(clk), .rst(rst), .s(pins_s), .mask(pin_chg_en), .hit(chg_hit)
  );

  always_comb begin
    fl_set         = '0;
    fl_set[FL_TMR] = tmr_roll;
    fl_set[FL_EXT] = ext_hit;
    fl_set[FL_CHG] = chg_hit;
  end

  for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
    ictl_flag #(.INIT((f == FL_CHG) ? CHG_INIT : 1'b0)) u_flag (
      .clk(clk), .rst(rst), .set(fl_set[f]), .wr(wr_en),
      .wd(wr_data[f]), .q(fl_q[f])
    );
  end

  logic [REG_W-1:EN_LO] en_q;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= wr_data[REG_W-1:EN_LO];
  end

  assign r = ictl_reg_t'({en_q, fl_q});

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= r.glb_en & ((r.tmr_en & r.tmr_fl) |
                                (r.ext_en & r.ext_fl) |
                                (r.chg_en & r.chg_fl) |
                                (r.per_en & periph_pend));
  end

  assign rd_data = r;
endmodule

// File: rtl/intc_reg_chk.sv
module intc_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       tmr_roll,
  input logic       periph_pend,
  input logic [7:0] rd_data,
  input logic       irq
);
  assert_enable_write_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[7:3] == $past(wr_data[7:3])));

  assert_sticky_tmr_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_data[2] && !wr_en) |=> rd_data[2]);

  assert_sticky_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_data[1] && !wr_en) |=> rd_data[1]);

  assert_sticky_chg_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_data[0] && !wr_en) |=> rd_data[0]);

  assert_global_mask_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_data[7] |=> !irq);

  assert_tmr_request_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] && rd_data[5] && rd_data[2]) |=> irq);

  assert_periph_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[6] && !(rd_data[5] && rd_data[2]) && !(rd_data[4] && rd_data[1])
     && !(rd_data[3] && rd_data[0]) && periph_pend) |=> !irq);

  assert_tmr_set_R7: assert property (@(posedge clk) disable iff (rst)
    tmr_roll |=> rd_data[2]);

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> ((rd_data[7:1] == 7'd0) && !irq));
endmodule

bind intc_reg intc_reg_chk u_chk (.*);

// File: tb/tb_intc_reg.sv
module tb_intc_reg;
  localparam int unsigned PINS = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_data = '0;
  logic [7:0]      rd_data;
  logic            tmr_roll = 1'b0;
  logic            ext_pin = 1'b0;
  logic [PINS-1:0] port_pins = '0;
  logic [PINS-1:0] pin_chg_en = 8'h01;
  logic            periph_pend = 1'b0;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  intc_reg #(.PINS(PINS)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tmr_roll(tmr_roll), .ext_pin(ext_pin), .port_pins(port_pins),
    .pin_chg_en(pin_chg_en), .periph_pend(periph_pend), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic irq_model(logic [7:0] m, logic pend);
    return m[7] & ((m[5] & m[2]) | (m[4] & m[1]) | (m[3] & m[0]) | (m[6] & pend));
  endfunction

  function automatic logic [7:0] next_model(logic [7:0] m, logic wr, logic [7:0] d,
                                            logic roll);
    logic [7:0] n;
    n    = wr ? d : m;
    n[2] = n[2] | roll;
    return n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic [7:0] m;
    logic [7:0] nm;
    logic       ei;
    void'($urandom(32'h1c3a5));
    cyc(3);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 reset register", {24'd0, rd_data}, 32'h00);
    chk("R11 reset irq", {31'd0, irq}, 32'd0);

    m = 8'h00;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wr_en       = ($urandom % 4) == 0;
      wr_data     = 8'($urandom);
      tmr_roll    = ($urandom % 7) == 0;
      periph_pend = $urandom % 2;
      ei = irq_model(m, periph_pend);
      nm = next_model(m, wr_en, wr_data, tmr_roll);
      @(posedge clk);
      #1;
      chk("R1 R3 R7 register", {24'd0, rd_data}, {24'd0, nm});
      chk("R5 irq", {31'd0, irq}, {31'd0, ei});
      m = nm;
    end
    @(negedge clk);
    wr_en = 1'b0; tmr_roll = 1'b0; periph_pend = 1'b0;

    wr(8'h00);
    chk("R3 clear all", {24'd0, rd_data}, 32'h00);

    // R10: rollover and clearing write in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h00; tmr_roll = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0; tmr_roll = 1'b0;
    chk("R10 set wins", {31'd0, rd_data[2]}, 32'd1);
    wr(8'h00);
    chk("R3 write zero clears", {24'd0, rd_data}, 32'h00);

    // R2 / R4: flag latches with everything disabled, irq stays low
    @(negedge clk);
    tmr_roll = 1'b1;
    cyc(1);
    tmr_roll = 1'b0;
    chk("R2 flag without enable", {31'd0, rd_data[2]}, 32'd1);
    cyc(2);
    chk("R4 global mask", {31'd0, irq}, 32'd0);
    wr(8'h24);
    cyc(2);
    chk("R4 global mask with source enabled", {31'd0, irq}, 32'd0);
    wr(8'hA4);
    cyc(1);
    chk("R5 timer request", {31'd0, irq}, 32'd1);

    // R6: peripheral enable gates the pending line
    wr(8'h80);
    @(negedge clk);
    periph_pend = 1'b1;
    cyc(2);
    chk("R6 peripheral mask", {31'd0, irq}, 32'd0);
    wr(8'hC0);
    cyc(1);
    chk("R6 peripheral request", {31'd0, irq}, 32'd1);
    @(negedge clk);
    periph_pend = 1'b0;
    cyc(1);
    chk("R5 pending removed", {31'd0, irq}, 32'd0);

    // R8: external rising edge through the synchronizer
    wr(8'h00);
    @(negedge clk);
    ext_pin = 1'b1;
    cyc(2);
    chk("R8 ext not yet", {31'd0, rd_data[1]}, 32'd0);
    cyc(1);
    chk("R8 ext rising", {31'd0, rd_data[1]}, 32'd1);
    wr(8'h00);
    @(negedge clk);
    ext_pin = 1'b0;
    cyc(5);
    chk("R8 ext falling ignored", {31'd0, rd_data[1]}, 32'd0);

    // R9: port change on masked and enabled pins
    @(negedge clk);
    port_pins[2] = 1'b1;
    cyc(5);
    chk("R9 masked pin ignored", {31'd0, rd_data[0]}, 32'd0);
    @(negedge clk);
    port_pins[0] = 1'b1;
    cyc(2);
    chk("R9 change not yet", {31'd0, rd_data[0]}, 32'd0);
    cyc(1);
    chk("R9 enabled pin rise", {31'd0, rd_data[0]}, 32'd1);
    wr(8'h00);
    @(negedge clk);
    port_pins[0] = 1'b0;
    cyc(3);
    chk("R9 enabled pin fall", {31'd0, rd_data[0]}, 32'd1);
    wr(8'h00);
    cyc(3);
    chk("R9 no further change", {31'd0, rd_data[0]}, 32'd0);

    // R3: writing ones sets flags
    wr(8'h07);
    chk("R3 write one sets", {24'd0, rd_data}, 32'h07);
    wr(8'h18);
    chk("R1 enables only", {24'd0, rd_data}, 32'h18);

    done = 1'b1;
    report();
  end
endmodule